// File: doc/BRIEF.md
# Oversampled Symbol Timing Tracker

This block paces the symbol decisions of an FSK demodulator whose discriminator output is sampled eight times per nominal symbol. A down-counter runs on the sample-clock enable. When it expires, the block raises a one-cycle decision strobe. In that cycle the surrounding demodulator presents two things: the eight-bit window of its middle-threshold samples, and the MSB it has decided from that window.

The tracker finds the samples in the window that agree with the decided MSB and takes the rounded mean of their bit positions. That mean shows whether the symbol energy sits early or late in the window. The counter is then reloaded for 9, 8 or 7 enables, so that the following decision is delayed, kept or advanced by one sample. A two-bit status output records which correction was chosen. It holds that value until the next decision.

Top module: `symtime_tracker`

## Requirements
- R1: After reset, `earlyLate` is 2'b00 and the down-counter holds 8. `symStrobe` is first asserted in the cycle that carries the 8th `sampleEn` after reset.
- R2: `symStrobe` is high only in a cycle with `sampleEn` high. It is never high in two consecutive cycles.
- R3: Window bit i is the sample taken i enables before the most recent one, so bit 0 is the newest. A bit counts as matching when its value equals `msbDecided`, whether that value is 0 or 1.
- R4: If fewer than 2 window bits match at a decision, the next strobe comes 8 enables later and `earlyLate` becomes 2'b00.
- R5: If the rounded mean index of the matching bits is 0, 1 or 2, the next strobe comes 9 enables later and `earlyLate` becomes 2'b01 (late).
- R6: If the rounded mean index is 3 or 4, the next strobe comes 8 enables later and `earlyLate` becomes 2'b00. A mean of exactly 2.5 rounds up to 3.
- R7: If the rounded mean index is 5, 6 or 7, the next strobe comes 7 enables later and `earlyLate` becomes 2'b10 (early). A mean of exactly 4.5 rounds up to 5.
- R8: `earlyLate` changes only on the clock edge that ends a strobe cycle. In every other cycle it holds.
- R9: A cycle with `sampleEn` low does not advance the interval count and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Sample-clock enable, one pulse per oversample |
| midWindow | input | 8 | Middle-threshold sample window, bit 0 newest |
| msbDecided | input | 1 | MSB decided for the current symbol |
| symStrobe | output | 1 | One-cycle symbol decision strobe |
| earlyLate | output | 2 | Last correction: 00 on time, 01 late, 10 early |

## Verification
The assertions make three assumptions:
- Reset is held for at least one edge before operation.
- `midWindow` and `msbDecided` are settled in a strobe cycle.
- `sampleEn` may stay low for any stretch without upsetting the interval.

The stimulus changes every input at the falling clock edge. It keeps the window steady for a whole symbol in the directed cases and randomises it every cycle in the open phase. It also drops `sampleEn` at random so that idle gaps fall both inside intervals and next to decision points.

// File: rtl/symtime_pkg.sv
package symtime_pkg;

  typedef enum logic [1:0] {
    PH_ON    = 2'b00,
    PH_LATE  = 2'b01,
    PH_EARLY = 2'b10
  } phase_e;

  typedef struct packed {
    logic decide;
    logic count;
  } tt_ctrl_t;

endpackage

// File: rtl/symtime_datapath.sv
module symtime_datapath
  import symtime_pkg::*;
#(
  parameter int OSR       = 8,
  parameter int MIN_MATCH = 2,
  parameter int CNT_W     = $clog2(OSR + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tt_ctrl_t         ctrl,
  input  logic [OSR-1:0]   midWindow,
  input  logic             msbDecided,
  output logic [CNT_W-1:0] nextInterval,
  output logic [1:0]       earlyLate
);

  localparam int SUM_W = $clog2(OSR * (OSR - 1) / 2 + 1);
  localparam int PW    = $clog2((OSR + 1) * OSR + 1) + 1;

  logic [CNT_W-1:0] matchCnt;
  logic [SUM_W-1:0] idxSum;
  logic [PW-1:0]    twiceSum, lateLim, earlyLim;
  phase_e           phase, phaseQ;

  // Count the agreeing samples and sum their positions.
  always_comb begin
    matchCnt = '0;
    idxSum   = '0;
    for (int i = 0; i < OSR; i++) begin
      if (midWindow[i] == msbDecided) begin
        matchCnt = matchCnt + CNT_W'(1);
        idxSum   = idxSum + SUM_W'(i);
      end
    end
  end

  // Compare the rounded mean with the region limits without dividing.
  // A late centre is a mean below OSR/2-1.5; an early centre is a mean of OSR/2+0.5 or more.
  always_comb begin
    twiceSum = PW'(idxSum) << 1;
    lateLim  = PW'(matchCnt) * PW'(OSR - 3);
    earlyLim = PW'(matchCnt) * PW'(OSR + 1);
    if (matchCnt < CNT_W'(MIN_MATCH))
      phase = PH_ON;
    else if (twiceSum < lateLim)
      phase = PH_LATE;
    else if (twiceSum >= earlyLim)
      phase = PH_EARLY;
    else
      phase = PH_ON;
  end

  always_comb begin
    unique case (phase)
      PH_LATE:  nextInterval = CNT_W'(OSR + 1);
      PH_EARLY: nextInterval = CNT_W'(OSR - 1);
      default:  nextInterval = CNT_W'(OSR);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      phaseQ <= PH_ON;
    else if (ctrl.decide)
      phaseQ <= phase;
  end

  assign earlyLate = phaseQ;

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.decide |=> $stable(earlyLate));

  assert_sparse_on_time_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.decide && (matchCnt < CNT_W'(MIN_MATCH))) |=> (earlyLate == 2'b00));

  assert_legal_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    earlyLate != 2'b11);

endmodule

// File: rtl/symtime_control.sv
module symtime_control
  import symtime_pkg::*;
#(
  parameter int OSR   = 8,
  parameter int CNT_W = $clog2(OSR + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleEn,
  input  logic [CNT_W-1:0] nextInterval,
  output tt_ctrl_t         ctrl,
  output logic             symStrobe
);

  logic [CNT_W-1:0] remaining;

  always_comb begin
    ctrl.decide = sampleEn && (remaining == CNT_W'(1));
    ctrl.count  = sampleEn && (remaining != CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      remaining <= CNT_W'(OSR);
    else if (ctrl.decide)
      remaining <= nextInterval;
    else if (ctrl.count)
      remaining <= remaining - CNT_W'(1);
  end

  assign symStrobe = ctrl.decide;

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> $stable(remaining));

  assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    symStrobe |=> !symStrobe);

  assert_reload_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.decide |=> ((remaining >= CNT_W'(OSR - 1)) && (remaining <= CNT_W'(OSR + 1))));

  assert_count_nonzero_R1: assert property (@(posedge clk) disable iff (!rstN)
    remaining != '0);

endmodule

// File: rtl/symtime_tracker.sv
module symtime_tracker
  import symtime_pkg::*;
#(
  parameter int OSR       = 8,
  parameter int MIN_MATCH = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sampleEn,
  input  logic [OSR-1:0] midWindow,
  input  logic           msbDecided,
  output logic           symStrobe,
  output logic [1:0]     earlyLate
);

  localparam int CNT_W = $clog2(OSR + 2);

  tt_ctrl_t         ctrl;
  logic [CNT_W-1:0] nextInterval;

  symtime_control #(.OSR(OSR), .CNT_W(CNT_W)) control_i (
    .clk          (clk),
    .rstN         (rstN),
    .sampleEn     (sampleEn),
    .nextInterval (nextInterval),
    .ctrl         (ctrl),
    .symStrobe    (symStrobe)
  );

  symtime_datapath #(.OSR(OSR), .MIN_MATCH(MIN_MATCH), .CNT_W(CNT_W)) datapath_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .midWindow    (midWindow),
    .msbDecided   (msbDecided),
    .nextInterval (nextInterval),
    .earlyLate    (earlyLate)
  );

endmodule

// File: tb/symtime_tracker_tb.sv
module symtime_tracker_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       sampleEn;
  logic [7:0] midWindow;
  logic       msbDecided;
  logic       symStrobe;
  logic [1:0] earlyLate;

  int compared   = 0;
  int mismatched = 0;
  int cycles     = 0;
  bit done       = 0;

  // reference state
  int       remRef;
  bit [1:0] flagRef;

  always #4 clk = ~clk;

  symtime_tracker dut_i (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .midWindow(midWindow),
    .msbDecided(msbDecided), .symStrobe(symStrobe), .earlyLate(earlyLate)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // Classify a window behaviourally: 0 on time, 1 late, 2 early; returns interval.
  function automatic int refInterval(input bit [7:0] win, input bit msb, output bit [1:0] fl);
    int n = 0, s = 0, centre;
    for (int i = 0; i < 8; i++) if (win[i] == msb) begin n++; s += i; end
    if (n < 2) begin fl = 2'b00; return 8; end
    centre = (2 * s + n) / (2 * n);
    if (centre <= 2) begin fl = 2'b01; return 9; end
    if (centre >= 5) begin fl = 2'b10; return 7; end
    fl = 2'b00;
    return 8;
  endfunction

  // One cycle: drive at negedge, compare, advance the reference. Returns 1 on a strobe.
  task automatic runCycle(input bit en, input bit [7:0] win, input bit msb,
                          input string tag, output bit fired);
    bit expStrobe;
    bit [1:0] fl;
    @(negedge clk);
    sampleEn = en; midWindow = win; msbDecided = msb;
    #1;
    expStrobe = en && (remRef == 1);
    compared++;
    if (symStrobe !== expStrobe) begin
      mismatched++;
      $display("FAIL %s strobe: actual %b expected %b", tag, symStrobe, expStrobe);
    end
    compared++;
    if (earlyLate !== flagRef) begin
      mismatched++;
      $display("FAIL %s earlyLate: actual %b expected %b", tag, earlyLate, flagRef);
    end
    if (expStrobe) begin
      remRef  = refInterval(win, msb, fl);
      flagRef = fl;
    end else if (en) begin
      remRef--;
    end
    fired = expStrobe;
  endtask

  // Run until one strobe has consumed the given window, plus one cycle to see the flags.
  task automatic runSymbol(input bit [7:0] win, input bit msb, input bit gaps, input string tag);
    bit fired = 0;
    bit en;
    while (!fired) begin
      en = gaps ? (($urandom % 4) != 0) : 1'b1;
      runCycle(en, win, msb, tag, fired);
    end
    runCycle(1'b0, win, msb, tag, fired);
  endtask

  initial begin
    bit f;
    rstN = 1'b0; sampleEn = 1'b0; midWindow = 8'h00; msbDecided = 1'b0;
    remRef = 8; flagRef = 2'b00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state and first strobe on the 8th enable
    runSymbol(8'h18, 1'b1, 1'b0, "R1");
    // R4: too few matches
    runSymbol(8'h00, 1'b1, 1'b0, "R4");
    runSymbol(8'h01, 1'b1, 1'b0, "R4");
    runSymbol(8'hFF, 1'b0, 1'b0, "R4");
    // R5: energy in newest samples
    runSymbol(8'h07, 1'b1, 1'b0, "R5");
    runSymbol(8'h03, 1'b1, 1'b0, "R5");
    // R3: matching on zero-valued samples
    runSymbol(8'hF8, 1'b0, 1'b0, "R3");
    runSymbol(8'h1F, 1'b0, 1'b0, "R3");
    // R6: centred, including the 2.5 boundary
    runSymbol(8'h18, 1'b1, 1'b0, "R6");
    runSymbol(8'h0C, 1'b1, 1'b0, "R6");
    runSymbol(8'hFF, 1'b1, 1'b0, "R6");
    // R7: energy in older samples, including the 4.5 boundary
    runSymbol(8'hE0, 1'b1, 1'b0, "R7");
    runSymbol(8'h30, 1'b1, 1'b0, "R7");
    runSymbol(8'hC0, 1'b1, 1'b0, "R7");
    // R9: idle gaps inside intervals
    for (int k = 0; k < 20; k++) runSymbol(8'h07, 1'b1, 1'b1, "R9");
    for (int k = 0; k < 8; k++) runCycle(1'b0, 8'hAA, 1'b1, "R9", f);
    // R8 / R2: random windows every cycle with random gaps
    for (int k = 0; k < 4000; k++)
      runCycle(($urandom % 3) != 0, 8'($urandom), 1'($urandom), "R8", f);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule